// File: doc/BRIEF.md
# Amplifier Fault Manager and Reporter

This block sits next to a four half-bridge class-D power stage. It gathers the protection events raised by that stage and decides which half-bridges are placed in high impedance and which have only their high-side switch disabled. It drives two active-low flags: one for shutdown faults and one for the temperature warning. Faults are sorted two ways. A fault is either global or tied to one channel, and it is either held until a restart or cleared once its cause has gone.

A run input plays the role of the stage's restart control. While run is low, every half-bridge is held in high impedance and the fault flag is forced inactive. A rising edge on run clears the held faults, but only once a configurable hold-off has passed since the fault flag went active. An edge that comes too early is ignored. The output mode input selects bridged pairs or four single-ended outputs, and so sets how far a channel fault spreads. All event inputs may be asynchronous, and each is resynchronised through two flops before use.

Half-bridge index i maps to outputs A, B, C, D as bits 0, 1, 2, 3. Each outcome reaches the outputs within four clock cycles of the input change.

Top module: `amp_fault_mgr`

## Requirements
- R1: A pulse on `ovl_evt[i]` (overload) or `ocl_evt[i]` (latched overcurrent) drives `fault_n` low and sets `hiz` for half-bridge i, given that `run_en` is high.
- R2: When `mode_se`=0 (bridged), a channel fault on bit 0 or 1 sets `hiz[1:0]`=2'b11, and one on bit 2 or 3 sets `hiz[3:2]`=2'b11. When `mode_se`=1 (single-ended), only bit i is set.
- R3: `bst_uv[i]` raises `hs_off[i]` alone. It leaves `hiz` and `fault_n` unchanged, and `hs_off[i]` drops once the input drops.
- R4: While `sup_uv` or `por_evt` is high, `hiz`=4'hF and `fault_n`=0. Both outputs recover when the input falls, with no run toggle.
- R5: A pulse on `temp_shut` latches a global shutdown: `hiz`=4'hF and `fault_n`=0 after the input has dropped, until a valid run edge.
- R6: Channel faults from R1 stay held after their event ends. A valid rising edge of `run_en` clears them.
- R7: `temp_warn` drives `warn_n` low only while it is high. It has no effect on `hiz` or `fault_n`.
- R8: While `run_en` is low, `hiz`=4'hF and `fault_n`=1, whatever faults are present.
- R9: `pwm_act[i]`=0 puts channel i in high impedance, spread as in R2, and `fault_n` stays 1. With `pwm_act`=4'h0, all bits of `hiz` are set. The channel recovers when activity returns.
- R10: A rising edge of `run_en` that comes fewer than HOLDOFF_CYC cycles after `fault_n` fell clears nothing. A later edge clears the held faults.
- R11: After system reset: `hiz`=4'hF, `hs_off`=0, `fault_n`=1, `warn_n`=1, and no fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| run_en | input | 1 | Stage run control; low holds all in high impedance, rising edge clears held faults |
| mode_se | input | 1 | 0 bridged pairs, 1 four single-ended outputs |
| ovl_evt | input | 4 | Per half-bridge overload event |
| ocl_evt | input | 4 | Per half-bridge latched overcurrent event |
| bst_uv | input | 4 | Per half-bridge bootstrap undervoltage |
| pwm_act | input | 4 | Per channel input PWM present |
| sup_uv | input | 1 | Any supply below its undervoltage threshold |
| por_evt | input | 1 | Power-on reset active |
| temp_warn | input | 1 | Warning temperature exceeded |
| temp_shut | input | 1 | Shutdown temperature exceeded |
| hiz | output | 4 | Per half-bridge high-impedance enable |
| hs_off | output | 4 | Per half-bridge high-side disable |
| fault_n | output | 1 | Active-low shutdown fault flag |
| warn_n | output | 1 | Active-low temperature warning flag |

## Verification
The bench drives every half-bridge, with both fault kinds and both output modes, and checks each resulting `hiz` mask against the expected spread. A design that decoded the pairs wrongly would shut down the wrong half of the stage. The hold-off test raises run too early, then raises it again after the window. A design that cleared on the first edge would leave the stage free to restart while still hot. Every PWM-activity pattern and every bootstrap pattern is swept. These sweeps catch a design that reports unreported events on `fault_n`, or that turns a high-side-only event into a full shutdown.

// File: rtl/afm_pkg.sv
// Shared sizes and types for the amplifier fault manager.
// Assumes an even half-bridge count, grouped into bridged pairs.
package afm_pkg;
    localparam int HB_N   = 4;
    localparam int PAIR_N = HB_N / 2;

    typedef logic [HB_N-1:0] hb_vec_t;

    typedef enum logic {
        MODE_BRIDGED = 1'b0,
        MODE_SINGLE  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/afm_sync.sv
// Two-flop synchronizer for a vector of unrelated asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is implied.
module afm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/afm_latch.sv
// Holds latched faults (per half-bridge and the thermal shutdown) and
// times the hold-off window that a run edge must respect to clear them.
// Assumes all inputs are already synchronous to clk.
module afm_latch
    import afm_pkg::*;
#(
    parameter int HOLDOFF_CYC = 800000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_s,
    input  hb_vec_t chan_evt,
    input  logic    ote_evt,
    input  logic    self_clr_flt,
    output hb_vec_t chan_lat,
    output logic    ote_lat,
    output logic    fault_any
);
    localparam int CW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(HOLDOFF_CYC);

    logic          run_q;
    logic          fault_any_q;
    logic [CW-1:0] hold_cnt;
    logic          hold_ok;
    logic          run_rise;
    logic          clr;

    assign run_rise  = run_s & ~run_q;
    assign hold_ok   = (hold_cnt == CNT_MAX);
    assign clr       = run_rise & hold_ok;
    assign fault_any = self_clr_flt | ote_lat | (|chan_lat);

    // Delayed copies for edge detection of run and of the fault summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            fault_any_q <= 1'b0;
        end else begin
            run_q       <= run_s;
            fault_any_q <= fault_any;
        end
    end

    // Hold-off counter: restarts when the fault summary rises, saturates at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= CNT_MAX;
        end else if (fault_any & ~fault_any_q) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CNT_MAX) begin
            hold_cnt <= hold_cnt + CW'(1);
        end
    end

    // Per half-bridge latch: an active event wins over a clearing edge.
    for (genvar h = 0; h < HB_N; h++) begin : g_lat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_lat[h] <= 1'b0;
            end else begin
                chan_lat[h] <= chan_evt[h] | (chan_lat[h] & ~clr);
            end
        end
    end

    // Global thermal shutdown latch, cleared by the same qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ote_lat <= 1'b0;
        end else begin
            ote_lat <= ote_evt | (ote_lat & ~clr);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= CNT_MAX); // R10

    AST_NO_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ok |=> ((chan_lat & $past(chan_lat)) == $past(chan_lat))
                     && (!$past(ote_lat) || ote_lat)); // R10
endmodule

// File: rtl/afm_route.sv
// Turns held and live fault state into registered per half-bridge
// high-impedance and high-side disables, plus the two active-low flags.
// Assumes inputs are synchronous; mode may change at any time.
module afm_route
    import afm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      run_s,
    input  logic      glob_flt,
    input  logic      fault_any,
    input  hb_vec_t   chan_lat,
    input  hb_vec_t   pwm_s,
    input  hb_vec_t   bst_s,
    input  logic      warn_s,
    output hb_vec_t   hiz,
    output hb_vec_t   hs_off,
    output logic      fault_n,
    output logic      warn_n
);
    hb_vec_t ch_bad;
    hb_vec_t spread;
    logic    all_lost;
    logic    glob_off;

    assign ch_bad   = chan_lat | ~pwm_s;
    assign all_lost = ~(|pwm_s);
    assign glob_off = ~run_s | glob_flt | all_lost;

    // Spread a channel fault across its bridged pair unless single-ended.
    for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
        logic pair_bad;
        assign pair_bad = ch_bad[2*p] | ch_bad[2*p+1];
        for (genvar k = 0; k < 2; k++) begin : g_side
            assign spread[2*p+k] = (mode == MODE_SINGLE) ? ch_bad[2*p+k] : pair_bad;
        end

        AST_BTL_PAIR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_BRIDGED) |=> (hiz[2*p] == hiz[2*p+1])); // R2
    end

    // Registered outputs toward the power stage and the system flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz     <= '1;
            hs_off  <= '0;
            fault_n <= 1'b1;
            warn_n  <= 1'b1;
        end else begin
            hiz     <= glob_off ? '1 : spread;
            hs_off  <= bst_s;
            fault_n <= ~(run_s & fault_any);
            warn_n  <= ~warn_s;
        end
    end

    AST_RUN_LOW_ALL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> (&hiz)); // R8

    AST_RUN_LOW_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> fault_n); // R8
endmodule

// File: rtl/amp_fault_mgr.sv
// Top of the amplifier fault manager: synchronizes the raw protection
// events, latches the held faults and drives the stage disables and flags.
// Assumes mode_se is static or changes only while run_en is low.
module amp_fault_mgr
    import afm_pkg::*;
#(
    parameter int HOLDOFF_CYC = 800000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       mode_se,
    input  logic [3:0] ovl_evt,
    input  logic [3:0] ocl_evt,
    input  logic [3:0] bst_uv,
    input  logic [3:0] pwm_act,
    input  logic       sup_uv,
    input  logic       por_evt,
    input  logic       temp_warn,
    input  logic       temp_shut,
    output logic [3:0] hiz,
    output logic [3:0] hs_off,
    output logic       fault_n,
    output logic       warn_n
);
    localparam int SYNC_W = 4 * HB_N + 5;

    logic [SYNC_W-1:0] raw_v;
    logic [SYNC_W-1:0] syn_v;

    hb_vec_t ovl_s, ocl_s, bst_s, pwm_s;
    logic    sup_s, por_s, warn_s, shut_s, run_s;
    hb_vec_t chan_lat;
    logic    ote_lat;
    logic    fault_any;
    logic    self_clr;
    hb_vec_t hiz_i, hs_off_i;

    assign raw_v = {run_en, temp_shut, temp_warn, por_evt, sup_uv,
                    pwm_act, bst_uv, ocl_evt, ovl_evt};
    assign {run_s, shut_s, warn_s, por_s, sup_s,
            pwm_s, bst_s, ocl_s, ovl_s} = syn_v;

    assign self_clr = sup_s | por_s;

    afm_sync #(.W(SYNC_W)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_v),
        .d_sync  (syn_v)
    );

    afm_latch #(.HOLDOFF_CYC(HOLDOFF_CYC)) i_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_s        (run_s),
        .chan_evt     (ovl_s | ocl_s),
        .ote_evt      (shut_s),
        .self_clr_flt (self_clr),
        .chan_lat     (chan_lat),
        .ote_lat      (ote_lat),
        .fault_any    (fault_any)
    );

    afm_route i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (out_mode_e'(mode_se)),
        .run_s     (run_s),
        .glob_flt  (self_clr | ote_lat),
        .fault_any (fault_any),
        .chan_lat  (chan_lat),
        .pwm_s     (pwm_s),
        .bst_s     (bst_s),
        .warn_s    (warn_s),
        .hiz       (hiz_i),
        .hs_off    (hs_off_i),
        .fault_n   (fault_n),
        .warn_n    (warn_n)
    );

    assign hiz    = hiz_i;
    assign hs_off = hs_off_i;

    AST_SUPPLY_SHUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (self_clr && run_s) |=> (!fault_n && (&hiz))); // R4

    AST_THERMAL_SHUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ote_lat |=> (&hiz)); // R5
endmodule

// File: tb/test_amp_fault_mgr.sv
module test_amp_fault_mgr;
    localparam int HOLD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       mode_se = 1'b0;
    logic [3:0] ovl_evt = '0, ocl_evt = '0, bst_uv = '0, pwm_act = 4'hF;
    logic       sup_uv = 1'b0, por_evt = 1'b0, temp_warn = 1'b0, temp_shut = 1'b0;
    logic [3:0] hiz, hs_off;
    logic       fault_n, warn_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    amp_fault_mgr #(.HOLDOFF_CYC(HOLD)) i_amp_fault_mgr (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_se(mode_se),
        .ovl_evt(ovl_evt), .ocl_evt(ocl_evt), .bst_uv(bst_uv), .pwm_act(pwm_act),
        .sup_uv(sup_uv), .por_evt(por_evt), .temp_warn(temp_warn), .temp_shut(temp_shut),
        .hiz(hiz), .hs_off(hs_off), .fault_n(fault_n), .warn_n(warn_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] spread(input logic [3:0] bad, input logic se);
        if (se) return bad;
        return {{2{|bad[3:2]}}, {2{|bad[1:0]}}};
    endfunction

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Wait out the hold-off window, then toggle run to clear held faults.
    task automatic valid_clear();
        tick(HOLD + 8);
        run_en = 1'b0;
        tick(4);
        run_en = 1'b1;
        tick(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        tick(3);
        // R11 reset state
        chk("R11 hiz", hiz, 4'hF);
        chk("R11 hs_off", hs_off, 4'h0);
        chk("R11 fault_n", {3'b0, fault_n}, 4'h1);
        chk("R11 warn_n", {3'b0, warn_n}, 4'h1);
        rst_n = 1'b1;
        tick(6);
        // R8 run low holds everything off
        chk("R8 hiz run low", hiz, 4'hF);
        run_en = 1'b1;
        tick(6);
        chk("R11 running no fault hiz", hiz, 4'h0);
        chk("R11 running fault_n", {3'b0, fault_n}, 4'h1);

        // R1 R2 R6 sweep of both fault kinds, each half-bridge, both modes
        for (int m = 0; m < 2; m++) begin
            for (int kind = 0; kind < 2; kind++) begin
                for (int h = 0; h < 4; h++) begin
                    mode_se = m[0];
                    tick(4);
                    if (kind == 0) ovl_evt = 4'(1 << h); else ocl_evt = 4'(1 << h);
                    tick(3);
                    ovl_evt = '0;
                    ocl_evt = '0;
                    tick(6);
                    chk("R1 fault_n low", {3'b0, fault_n}, 4'h0);
                    chk("R2 hiz spread", hiz, spread(4'(1 << h), m[0]));
                    tick(5);
                    chk("R6 still held", hiz, spread(4'(1 << h), m[0]));
                    valid_clear();
                    chk("R6 cleared hiz", hiz, 4'h0);
                    chk("R6 cleared fault_n", {3'b0, fault_n}, 4'h1);
                end
            end
        end
        mode_se = 1'b0;
        tick(4);

        // R10 premature run edge ignored, later edge clears
        ovl_evt = 4'h4;
        tick(3);
        ovl_evt = '0;
        tick(4);
        run_en = 1'b0;
        tick(4);
        chk("R8 fault masked", {3'b0, fault_n}, 4'h1);
        run_en = 1'b1;
        tick(6);
        chk("R10 early edge fault_n", {3'b0, fault_n}, 4'h0);
        chk("R10 early edge hiz", hiz, 4'hC);
        valid_clear();
        chk("R10 late edge hiz", hiz, 4'h0);
        chk("R10 late edge fault_n", {3'b0, fault_n}, 4'h1);

        // R5 thermal shutdown latched, also gated by hold-off
        temp_shut = 1'b1;
        tick(3);
        temp_shut = 1'b0;
        tick(8);
        chk("R5 hiz held", hiz, 4'hF);
        chk("R5 fault_n", {3'b0, fault_n}, 4'h0);
        run_en = 1'b0;
        tick(3);
        run_en = 1'b1;
        tick(6);
        chk("R10 early edge thermal", {3'b0, fault_n}, 4'h0);
        valid_clear();
        chk("R5 cleared hiz", hiz, 4'h0);
        chk("R5 cleared fault_n", {3'b0, fault_n}, 4'h1);

        // R4 supply fault and power-on reset, self-clearing; R8 masking
        for (int s = 0; s < 2; s++) begin
            if (s == 0) sup_uv = 1'b1; else por_evt = 1'b1;
            tick(6);
            chk("R4 hiz", hiz, 4'hF);
            chk("R4 fault_n", {3'b0, fault_n}, 4'h0);
            run_en = 1'b0;
            tick(6);
            chk("R8 fault_n forced high", {3'b0, fault_n}, 4'h1);
            chk("R8 hiz", hiz, 4'hF);
            run_en = 1'b1;
            tick(6);
            sup_uv = 1'b0;
            por_evt = 1'b0;
            tick(6);
            chk("R4 recovered hiz", hiz, 4'h0);
            chk("R4 recovered fault_n", {3'b0, fault_n}, 4'h1);
        end

        // R7 warning only affects warn_n
        temp_warn = 1'b1;
        tick(6);
        chk("R7 warn_n low", {3'b0, warn_n}, 4'h0);
        chk("R7 hiz untouched", hiz, 4'h0);
        chk("R7 fault_n untouched", {3'b0, fault_n}, 4'h1);
        temp_warn = 1'b0;
        tick(6);
        chk("R7 warn_n released", {3'b0, warn_n}, 4'h1);

        // R3 bootstrap undervoltage sweep
        for (int p = 0; p < 16; p++) begin
            bst_uv = 4'(p);
            tick(6);
            chk("R3 hs_off", hs_off, 4'(p));
            chk("R3 hiz", hiz, 4'h0);
            chk("R3 fault_n", {3'b0, fault_n}, 4'h1);
        end
        bst_uv = '0;
        tick(6);
        chk("R3 hs_off cleared", hs_off, 4'h0);

        // R9 PWM activity sweep in both modes
        for (int m = 0; m < 2; m++) begin
            mode_se = m[0];
            for (int p = 0; p < 16; p++) begin
                pwm_act = 4'(p);
                tick(6);
                chk("R9 hiz", hiz, (p == 0) ? 4'hF : spread(~4'(p), m[0]));
                chk("R9 fault_n", {3'b0, fault_n}, 4'h1);
            end
        end
        pwm_act = 4'hF;
        tick(6);
        chk("R9 recovered", hiz, 4'h0);

        finish_test();
    end
endmodule